// File: doc/BRIEF.md
# DRAM Command Spacing Checker

The block watches a stream of already decoded DRAM commands, one per controller clock, each with a bank number. It checks every command against the minimum spacings that an earlier command imposes, and it reports in the same cycle when a command arrives too early. On a violation it raises a flag for that cycle and gives a code that names the broken rule. The block never blocks, delays or alters the stream. It only observes it, so it can sit beside a controller as a protocol monitor.

Each spacing limit is a whole number of clock cycles. The limit is the larger of a fixed cycle floor and a time floor. The time floor is given in picoseconds and turns into cycles by rounding up against a clock period input that is also in picoseconds. Because of this, a single build stays correct across speed grades: changing the period input moves every limit that a time floor sets. The rules checked are activate-to-activate spacing, a rolling window over the last four activates, column-to-column spacing, write-to-read turnaround, read-to-precharge on the same bank, mode-register-to-mode-register spacing, and mode-register-to-other-command spacing.

Top module: `ddr_cmd_spacing_chk`

## Requirements
- R1: Command encoding on `cmd_code`: 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 mode-register set. Codes 6 and 7 act as idle. An idle cycle is never flagged. After reset every rule starts out satisfied, so the first command of any kind is legal.
- R2: Each limit in cycles is max(cycle floor, ceil(time floor ps / `tck_ps`)). With defaults and `tck_ps`=1875: activate spacing 4, activate window 20, mode-register-to-command 12. With `tck_ps`=1000: activate spacing 8 and mode-register-to-command 15.
- R3: An activate whose distance from the previous activate is below the activate spacing limit is flagged with code 3.
- R4: An activate that comes while the fourth-most-recent earlier activate is fewer cycles back than the window limit is flagged with code 4.
- R5: A read or write whose distance from the previous read or write is below 4 cycles is flagged with code 5.
- R6: A read whose distance from the previous write is below `WR_DATA_END` (default 10) plus max(4, ceil(7500/`tck_ps`)) is flagged with code 6.
- R7: A precharge to bank b whose distance from the last read to bank b is below max(4, ceil(7500/`tck_ps`)) is flagged with code 7. Reads to other banks do not count.
- R8: A mode-register set whose distance from the previous mode-register set is below 4 cycles is flagged with code 2.
- R9: An activate, read, write or precharge whose distance from the last mode-register set is below max(12, ceil(15000/`tck_ps`)) is flagged with code 1.
- R10: `viol` is high in exactly the cycle of the offending command. When `viol` is low, `viol_code` is 0, and when `viol` is high, `viol_code` is nonzero.
- R11: When one command breaks several rules, the lowest code is reported.
- R12: Every command updates the spacing history, whether or not it is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tck_ps | input | PS_W (16) | Clock period in picoseconds |
| cmd_code | input | 3 | Decoded command of this cycle |
| bank | input | log2(NUM_BANKS) (3) | Bank of the command |
| viol | output | 1 | Spacing violation in this cycle |
| viol_code | output | 3 | Broken rule, 0 when none |

## Verification
The activate spacing rule and the rolling four-activate window can both be broken by one activate. The bench sends four activates exactly at the spacing limit and then a fifth activate one cycle early. That fifth activate is inside the window and also too close to its neighbour, so code 3 is expected rather than 4. In a second collision case, a read after a write and a mode-register set breaks three rules at once, and the mode-register rule's code 1 is expected to win.

// File: rtl/ddr_spc_pkg.sv
package ddr_spc_pkg;

   localparam logic [2:0] CMD_NOP = 3'd0;
   localparam logic [2:0] CMD_ACT = 3'd1;
   localparam logic [2:0] CMD_RD  = 3'd2;
   localparam logic [2:0] CMD_WR  = 3'd3;
   localparam logic [2:0] CMD_PRE = 3'd4;
   localparam logic [2:0] CMD_MRS = 3'd5;

   typedef enum logic [2:0] {
      V_NONE = 3'd0,
      V_MOD  = 3'd1,
      V_MRD  = 3'd2,
      V_RRD  = 3'd3,
      V_FAW  = 3'd4,
      V_CCD  = 3'd5,
      V_WTR  = 3'd6,
      V_RTP  = 3'd7
   } viol_e;

endpackage

// File: rtl/spc_limit.sv
module spc_limit #(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned PS_W     = 16,
   parameter int unsigned MIN_CYC  = 4,
   parameter int unsigned FLOOR_PS = 7500,
   parameter int unsigned EXTRA    = 0
) (
   input  logic [PS_W-1:0]  tck_ps,
   output logic [CNT_W-1:0] limit
);
   localparam logic [31:0] SAT = 32'((64'd1 << CNT_W) - 64'd1);

   logic [31:0] period;
   logic [31:0] ns_cyc;
   logic [31:0] big;

   always_comb begin
      period = (tck_ps == '0) ? 32'd1 : 32'(tck_ps);
      ns_cyc = (32'(FLOOR_PS) + period - 32'd1) / period;
      big    = ((ns_cyc > 32'(MIN_CYC)) ? ns_cyc : 32'(MIN_CYC)) + 32'(EXTRA);
      limit  = (big > SAT) ? SAT[CNT_W-1:0] : big[CNT_W-1:0];
   end
endmodule

// File: rtl/spc_age.sv
module spc_age #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] age
);
   localparam logic [CNT_W-1:0] SAT = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)
         age <= SAT;
      else if (restart)
         age <= CNT_W'(1);
      else if (age != SAT)
         age <= age + CNT_W'(1);
   end
endmodule

// File: rtl/spc_act_window.sv
module spc_act_window #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic [CNT_W-1:0] limit,
   output logic             too_soon
);
   localparam logic [CNT_W-1:0] SAT = '1;

   logic [CNT_W-1:0] age [DEPTH];

   function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] a);
      return (a == SAT) ? SAT : a + CNT_W'(1);
   endfunction

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n)   age[i] <= SAT;
            else if (act) age[i] <= CNT_W'(1);
            else          age[i] <= bump(age[i]);
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n)   age[i] <= SAT;
            else if (act) age[i] <= bump(age[i-1]);
            else          age[i] <= bump(age[i]);
         end
      end
   end

   assign too_soon = act && (age[DEPTH-1] < limit);
endmodule

// File: rtl/ddr_cmd_spacing_chk.sv
module ddr_cmd_spacing_chk
   import ddr_spc_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 8,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned PS_W        = 16,
   parameter int unsigned FAW_DEPTH   = 4,
   parameter int unsigned RRD_CYC     = 4,
   parameter int unsigned RRD_PS      = 7500,
   parameter int unsigned FAW_PS      = 37500,
   parameter int unsigned CCD_CYC     = 4,
   parameter int unsigned WTR_CYC     = 4,
   parameter int unsigned WTR_PS      = 7500,
   parameter int unsigned WR_DATA_END = 10,
   parameter int unsigned RTP_CYC     = 4,
   parameter int unsigned RTP_PS      = 7500,
   parameter int unsigned MRD_CYC     = 4,
   parameter int unsigned MOD_CYC     = 12,
   parameter int unsigned MOD_PS      = 15000,
   localparam int unsigned BANK_W     = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PS_W-1:0]   tck_ps,
   input  logic [2:0]        cmd_code,
   input  logic [BANK_W-1:0] bank,
   output logic              viol,
   output logic [2:0]        viol_code
);
   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (CNT_W < 4 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W out of range");
   end
   if (PS_W < 4 || PS_W > 24) begin : g_bad_ps
      $error("PS_W out of range");
   end
   if (FAW_DEPTH < 1) begin : g_bad_depth
      $error("FAW_DEPTH must be at least 1");
   end
   if (MOD_CYC >= CNT_MAX || WR_DATA_END + WTR_CYC >= CNT_MAX) begin : g_bad_floor
      $error("cycle floors do not fit the age counters");
   end

   logic is_act, is_rd, is_wr, is_pre, is_mrs, is_col, is_cmd;

   always_comb begin
      is_act = (cmd_code == CMD_ACT);
      is_rd  = (cmd_code == CMD_RD);
      is_wr  = (cmd_code == CMD_WR);
      is_pre = (cmd_code == CMD_PRE);
      is_mrs = (cmd_code == CMD_MRS);
      is_col = is_rd | is_wr;
      is_cmd = is_act | is_col | is_pre;
   end

   logic [CNT_W-1:0] lim_rrd, lim_faw, lim_ccd, lim_wtr, lim_rtp, lim_mrd, lim_mod;

   spc_limit #(.CNT_W(CNT_W), .PS_W(PS_W), .MIN_CYC(RRD_CYC), .FLOOR_PS(RRD_PS), .EXTRA(0))
      u_lim_rrd (.tck_ps(tck_ps), .limit(lim_rrd));
   spc_limit #(.CNT_W(CNT_W), .PS_W(PS_W), .MIN_CYC(1), .FLOOR_PS(FAW_PS), .EXTRA(0))
      u_lim_faw (.tck_ps(tck_ps), .limit(lim_faw));
   spc_limit #(.CNT_W(CNT_W), .PS_W(PS_W), .MIN_CYC(CCD_CYC), .FLOOR_PS(0), .EXTRA(0))
      u_lim_ccd (.tck_ps(tck_ps), .limit(lim_ccd));
   spc_limit #(.CNT_W(CNT_W), .PS_W(PS_W), .MIN_CYC(WTR_CYC), .FLOOR_PS(WTR_PS),
               .EXTRA(WR_DATA_END))
      u_lim_wtr (.tck_ps(tck_ps), .limit(lim_wtr));
   spc_limit #(.CNT_W(CNT_W), .PS_W(PS_W), .MIN_CYC(RTP_CYC), .FLOOR_PS(RTP_PS), .EXTRA(0))
      u_lim_rtp (.tck_ps(tck_ps), .limit(lim_rtp));
   spc_limit #(.CNT_W(CNT_W), .PS_W(PS_W), .MIN_CYC(MRD_CYC), .FLOOR_PS(0), .EXTRA(0))
      u_lim_mrd (.tck_ps(tck_ps), .limit(lim_mrd));
   spc_limit #(.CNT_W(CNT_W), .PS_W(PS_W), .MIN_CYC(MOD_CYC), .FLOOR_PS(MOD_PS), .EXTRA(0))
      u_lim_mod (.tck_ps(tck_ps), .limit(lim_mod));

   logic [CNT_W-1:0] since_act, since_col, since_wr, since_mrs;

   spc_age #(.CNT_W(CNT_W)) u_age_act (.clk(clk), .rst_n(rst_n), .restart(is_act), .age(since_act));
   spc_age #(.CNT_W(CNT_W)) u_age_col (.clk(clk), .rst_n(rst_n), .restart(is_col), .age(since_col));
   spc_age #(.CNT_W(CNT_W)) u_age_wr  (.clk(clk), .rst_n(rst_n), .restart(is_wr),  .age(since_wr));
   spc_age #(.CNT_W(CNT_W)) u_age_mrs (.clk(clk), .rst_n(rst_n), .restart(is_mrs), .age(since_mrs));

   logic [CNT_W-1:0] since_rd [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic rd_here;
      assign rd_here = is_rd && (bank == BANK_W'(b));
      spc_age #(.CNT_W(CNT_W)) u_age_rd (
         .clk(clk), .rst_n(rst_n), .restart(rd_here), .age(since_rd[b]));
   end

   logic faw_hit;

   spc_act_window #(.CNT_W(CNT_W), .DEPTH(FAW_DEPTH)) u_window (
      .clk(clk), .rst_n(rst_n), .act(is_act), .limit(lim_faw), .too_soon(faw_hit));

   logic hit_mod, hit_mrd, hit_rrd, hit_ccd, hit_wtr, hit_rtp;
   viol_e code_sel;

   always_comb begin
      hit_mod = is_cmd && (since_mrs < lim_mod);
      hit_mrd = is_mrs && (since_mrs < lim_mrd);
      hit_rrd = is_act && (since_act < lim_rrd);
      hit_ccd = is_col && (since_col < lim_ccd);
      hit_wtr = is_rd  && (since_wr  < lim_wtr);
      hit_rtp = is_pre && (since_rd[bank] < lim_rtp);

      if (hit_mod)      code_sel = V_MOD;
      else if (hit_mrd) code_sel = V_MRD;
      else if (hit_rrd) code_sel = V_RRD;
      else if (faw_hit) code_sel = V_FAW;
      else if (hit_ccd) code_sel = V_CCD;
      else if (hit_wtr) code_sel = V_WTR;
      else if (hit_rtp) code_sel = V_RTP;
      else              code_sel = V_NONE;
   end

   assign viol      = (code_sel != V_NONE);
   assign viol_code = code_sel;
endmodule

// File: rtl/spc_chk_props.sv
module spc_chk_props
   import ddr_spc_pkg::*;
#(
   parameter int unsigned BANK_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cmd_code,
   input logic [BANK_W-1:0] bank,
   input logic              viol,
   input logic [2:0]        viol_code
);
   logic pv;

   always_ff @(posedge clk) begin
      if (!rst_n) pv <= 1'b0;
      else        pv <= 1'b1;
   end

   logic cur_cmd;
   assign cur_cmd = (cmd_code == CMD_ACT) || (cmd_code == CMD_RD) ||
                    (cmd_code == CMD_WR)  || (cmd_code == CMD_PRE);

   p_flag_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      viol == (viol_code != 3'd0));

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_NOP || cmd_code > CMD_MRS) |-> !viol);

   p_act_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && cmd_code == CMD_ACT && $past(cmd_code) == CMD_ACT) |-> viol);

   p_col_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && (cmd_code == CMD_RD || cmd_code == CMD_WR) &&
       ($past(cmd_code) == CMD_RD || $past(cmd_code) == CMD_WR)) |-> viol);

   p_mrs_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && cmd_code == CMD_MRS && $past(cmd_code) == CMD_MRS) |-> viol_code == 3'd2);

   p_mod_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && cur_cmd && $past(cmd_code) == CMD_MRS) |-> viol_code == 3'd1);

   p_rd_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && cmd_code == CMD_PRE && $past(cmd_code) == CMD_RD && $past(bank) == bank)
      |-> viol);
endmodule

bind ddr_cmd_spacing_chk spc_chk_props #(.BANK_W(BANK_W)) u_props (
   .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .bank(bank),
   .viol(viol), .viol_code(viol_code));

// File: tb/tb_ddr_cmd_spacing_chk.sv
module tb_ddr_cmd_spacing_chk;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tck_ps = 16'd1875;
   logic [2:0]  cmd_code = 3'd0;
   logic [2:0]  bank = 3'd0;
   logic        viol;
   logic [2:0]  viol_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, MRS = 3'd5;

   always #10 clk = ~clk;

   ddr_cmd_spacing_chk dut (
      .clk(clk), .rst_n(rst_n), .tck_ps(tck_ps), .cmd_code(cmd_code),
      .bank(bank), .viol(viol), .viol_code(viol_code));

   task automatic check(input string req, input logic [2:0] exp);
      checks++;
      if (viol !== (exp != 3'd0) || viol_code !== exp) begin
         errors++;
         $display("FAIL %s: viol=%0b code=%0d, expected viol=%0b code=%0d",
                  req, viol, viol_code, (exp != 3'd0), exp);
      end
   endtask

   task automatic send(input logic [2:0] c, input logic [2:0] b);
      @(negedge clk);
      cmd_code = c;
      bank = b;
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) send(NOP, 3'd0);
   endtask

   task automatic do_reset(input logic [15:0] period);
      @(negedge clk);
      rst_n = 1'b0;
      tck_ps = period;
      cmd_code = NOP;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset(16'd1875);
      #1; check("R1 idle after reset", 3'd0);
      send(ACT, 3'd0); check("R1 first activate", 3'd0);
      do_reset(16'd1875); send(RD, 3'd1);  check("R1 first read", 3'd0);
      do_reset(16'd1875); send(WR, 3'd1);  check("R1 first write", 3'd0);
      do_reset(16'd1875); send(PRE, 3'd1); check("R1 first precharge", 3'd0);
      do_reset(16'd1875); send(MRS, 3'd0); check("R1 first mode set", 3'd0);
      send(NOP, 3'd0); check("R1 idle right after mode set", 3'd0);
   endtask

   task automatic t_act_spacing();
      do_reset(16'd1875);
      send(ACT, 3'd0); idle(2); send(ACT, 3'd1); check("R3 activate gap 3", 3'd3);
      send(NOP, 3'd0); check("R10 flag lasts one cycle", 3'd0);
      do_reset(16'd1875);
      send(ACT, 3'd0); idle(3); send(ACT, 3'd1); check("R3 activate gap 4", 3'd0);
   endtask

   task automatic t_time_floor();
      do_reset(16'd1000);
      send(ACT, 3'd0); idle(6); send(ACT, 3'd1); check("R2 activate gap 7 at 1000ps", 3'd3);
      do_reset(16'd1000);
      send(ACT, 3'd0); idle(7); send(ACT, 3'd1); check("R2 activate gap 8 at 1000ps", 3'd0);
      do_reset(16'd1000);
      send(MRS, 3'd0); idle(13); send(ACT, 3'd0); check("R2 mode gap 14 at 1000ps", 3'd1);
      do_reset(16'd1000);
      send(MRS, 3'd0); idle(14); send(ACT, 3'd0); check("R2 mode gap 15 at 1000ps", 3'd0);
   endtask

   task automatic t_window();
      do_reset(16'd1875);
      send(ACT, 3'd0);
      for (int k = 1; k < 4; k++) begin
         idle(3); send(ACT, 3'(k)); check("R4 activates inside window", 3'd0);
      end
      idle(3); send(ACT, 3'd4); check("R4 fifth activate at 16", 3'd4);
      do_reset(16'd1875);
      send(ACT, 3'd0);
      for (int k = 1; k < 4; k++) begin idle(3); send(ACT, 3'(k)); end
      idle(7); send(ACT, 3'd4); check("R4 fifth activate at 20", 3'd0);
   endtask

   task automatic t_column();
      do_reset(16'd1875);
      send(RD, 3'd0); idle(2); send(WR, 3'd0); check("R5 read to write gap 3", 3'd5);
      do_reset(16'd1875);
      send(RD, 3'd0); idle(3); send(RD, 3'd1); check("R5 read to read gap 4", 3'd0);
   endtask

   task automatic t_turnaround();
      do_reset(16'd1875);
      send(WR, 3'd0); idle(12); send(RD, 3'd0); check("R6 write to read gap 13", 3'd6);
      do_reset(16'd1875);
      send(WR, 3'd0); idle(13); send(RD, 3'd0); check("R6 write to read gap 14", 3'd0);
   endtask

   task automatic t_read_pre();
      do_reset(16'd1875);
      send(RD, 3'd2); idle(1);
      send(PRE, 3'd3); check("R7 precharge other bank", 3'd0);
      send(PRE, 3'd2); check("R7 precharge same bank gap 3", 3'd7);
      idle(1);
      send(PRE, 3'd2); check("R7 precharge same bank gap 5", 3'd0);
   endtask

   task automatic t_mode();
      do_reset(16'd1875);
      send(MRS, 3'd0); idle(2); send(MRS, 3'd0); check("R8 mode to mode gap 3", 3'd2);
      idle(10); send(ACT, 3'd0); check("R9 mode to activate gap 11", 3'd1);
      do_reset(16'd1875);
      send(MRS, 3'd0); idle(3); send(MRS, 3'd0); check("R8 mode to mode gap 4", 3'd0);
      idle(11); send(PRE, 3'd0); check("R9 mode to precharge gap 12", 3'd0);
   endtask

   task automatic t_priority();
      do_reset(16'd1875);
      send(WR, 3'd0);
      send(MRS, 3'd0); check("R11 mode set after write", 3'd0);
      idle(1);
      send(RD, 3'd0); check("R11 three rules, mode rule wins", 3'd1);
      do_reset(16'd1875);
      send(ACT, 3'd0);
      for (int k = 1; k < 4; k++) begin idle(3); send(ACT, 3'(k)); end
      idle(2); send(ACT, 3'd4); check("R11 spacing beats window", 3'd3);
   endtask

   task automatic t_update_on_flag();
      do_reset(16'd1875);
      send(ACT, 3'd0); idle(2);
      send(ACT, 3'd1); check("R12 early activate", 3'd3);
      idle(1);
      send(ACT, 3'd2); check("R12 flagged activate still counts", 3'd3);
   endtask

   initial begin
      t_reset_state();
      t_act_spacing();
      t_time_floor();
      t_window();
      t_column();
      t_turnaround();
      t_read_pre();
      t_mode();
      t_priority();
      t_update_on_flag();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule